// File: doc/BRIEF.md
# Shared Monitoring-ADC Request Sequencer

This block is the digital sequencer in front of a single 10-bit monitoring converter that four users share. The users are a real-time hardware trigger, two independent software requesters and an internal USB requester. Each user raises a one-cycle request pulse. The real-time and software requesters supply a channel mask with the pulse. The USB requester always converts channel 12. Any requester may also ask for four-sample averaging. The sequencer arbitrates under fixed priority and walks the granted channel mask from the lowest channel upward. Before every conversion it waits a programmable acquisition time. It drives the converter through a start/done/data handshake.

Results are stored in quarter-LSB form. An averaged channel stores the 12-bit sum of four consecutive samples, so the two low bits are fractional. A single-sample channel stores its sample shifted left by two. Results are kept in a bank with one register per user and channel, and a combinational port reads them. When the last channel of a granted request has been written, the user's end-of-sequence bit pulses for one cycle. Requests that lose arbitration stay pending. A request that arrives during its own user's sequence is remembered and serviced once afterwards.

Top module: `adc_share_seq`

## Requirements
- R1: After reset, adc_start and eos_irq are low and every result register reads zero.
- R2: Pending requests are granted in fixed priority: real-time (user 0) first, then software 1 (user 1), then software 2 (user 2), then USB (user 3). User codes 0 to 3 are used on rd_user and as the bit index of eos_irq.
- R3: A request that loses arbitration stays pending and is serviced later; it is never dropped.
- R4: A granted request converts each channel set in its mask exactly once (more often only when averaging), lowest channel index first. The mask and averaging choice are captured with the request pulse.
- R5: Without averaging, the stored result is the 10-bit sample shifted left by two bits. Stored results are 12 bits wide, with the two low bits as fractional quarter-LSB bits.
- R6: With averaging, each channel is converted four times in a row and the stored result is the 12-bit sum of the four samples. Four full-scale samples give 4092.
- R7: A USB request converts only channel 12, once per request, and stores its result in the register for user 3 and channel 12.
- R8: The real-time request may select any channel, including channel 0 and the highest channel.
- R9: eos_irq pulses for one cycle on the granted user's bit once per sequence, after that sequence's results are stored. A request with an empty mask produces the pulse with no conversion.
- R10: Raising acq_time by N lengthens the interval between a conversion's done and the next adc_start by exactly N cycles.
- R11: Requests from a user that arrive while that user's sequence is running are merged into one pending request. That request is serviced once after the running sequence ends.
- R12: adc_start is a single-cycle pulse, and no further adc_start is issued until adc_done returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rt_req | input | 1 | Real-time request pulse |
| rt_mask | input | 16 | Real-time channel mask |
| rt_avg | input | 1 | Real-time averaging select |
| sw1_req | input | 1 | Software 1 request pulse |
| sw1_mask | input | 16 | Software 1 channel mask |
| sw1_avg | input | 1 | Software 1 averaging select |
| sw2_req | input | 1 | Software 2 request pulse |
| sw2_mask | input | 16 | Software 2 channel mask |
| sw2_avg | input | 1 | Software 2 averaging select |
| usb_req | input | 1 | USB request pulse (channel 12) |
| usb_avg | input | 1 | USB averaging select |
| acq_time | input | 8 | Acquisition wait in cycles before each start |
| adc_start | output | 1 | Converter start pulse |
| adc_ch | output | 4 | Channel under conversion |
| adc_done | input | 1 | Converter completion strobe |
| adc_data | input | 10 | Converter sample, valid with adc_done |
| eos_irq | output | 4 | End-of-sequence pulse, one bit per user |
| rd_user | input | 2 | Result read user select |
| rd_ch | input | 4 | Result read channel select |
| rd_val | output | 12 | Stored result, quarter-LSB |

## Verification
The bench builds the block with its defaults: 16 channels, 10-bit samples, an 8-bit acquisition counter and the USB channel at 12. With these values the bench can reach both channel edges (0 and 15) and the fixed USB channel inside one mask width. It can also reach the full-scale averaging sum of 4092 in the 12-bit result. Acquisition values of 0 and 6 fit the counter, so the bench compares the done-to-start interval across them.

// File: rtl/adc_share_pkg.sv
package adc_share_pkg;
    localparam int NUM_USERS = 4;
    localparam int USER_W    = 2;
    localparam int FRAC_W    = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_ACQ,
        ST_START,
        ST_WAIT
    } seq_st_e;
endpackage

// File: rtl/adc_share_arb.sv
module adc_share_arb #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic          gnt_vld,
    output logic [IW-1:0] gnt_idx
);
    // lowest index wins
    always_comb begin
        gnt_vld = 1'b0;
        gnt_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt_vld = 1'b1;
                gnt_idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/adc_share_pick.sv
module adc_share_pick #(
    parameter int CH_W = 4
) (
    input  logic [(1<<CH_W)-1:0] mask,
    output logic                 vld,
    output logic [CH_W-1:0]      idx
);
    localparam int NUM_CH = 1 << CH_W;

    always_comb begin
        vld = 1'b0;
        idx = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (mask[i]) begin
                vld = 1'b1;
                idx = CH_W'(i);
            end
        end
    end
endmodule

// File: rtl/adc_share_res.sv
module adc_share_res #(
    parameter int USER_W = 2,
    parameter int CH_W   = 4,
    parameter int RES_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [USER_W-1:0] wr_user,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [RES_W-1:0]  wr_val,
    input  logic [USER_W-1:0] rd_user,
    input  logic [CH_W-1:0]   rd_ch,
    output logic [RES_W-1:0]  rd_val
);
    localparam int DEPTH = 1 << (USER_W + CH_W);

    logic [RES_W-1:0] bank_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) bank_q[i] <= '0;
        end else if (we) begin
            bank_q[{wr_user, wr_ch}] <= wr_val;
        end
    end

    assign rd_val = bank_q[{rd_user, rd_ch}];
endmodule

// File: rtl/adc_share_seq.sv
module adc_share_seq
    import adc_share_pkg::*;
#(
    parameter int CH_W   = 4,
    parameter int DATA_W = 10,
    parameter int ACQ_W  = 8,
    parameter int USB_CH = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rt_req,
    input  logic [(1<<CH_W)-1:0]          rt_mask,
    input  logic                          rt_avg,
    input  logic                          sw1_req,
    input  logic [(1<<CH_W)-1:0]          sw1_mask,
    input  logic                          sw1_avg,
    input  logic                          sw2_req,
    input  logic [(1<<CH_W)-1:0]          sw2_mask,
    input  logic                          sw2_avg,
    input  logic                          usb_req,
    input  logic                          usb_avg,
    input  logic [ACQ_W-1:0]              acq_time,
    output logic                          adc_start,
    output logic [CH_W-1:0]               adc_ch,
    input  logic                          adc_done,
    input  logic [DATA_W-1:0]             adc_data,
    output logic [NUM_USERS-1:0]          eos_irq,
    input  logic [USER_W-1:0]             rd_user,
    input  logic [CH_W-1:0]               rd_ch,
    output logic [DATA_W+FRAC_W-1:0]      rd_val
);
    localparam int NUM_CH = 1 << CH_W;
    localparam int RES_W  = DATA_W + FRAC_W;
    localparam int NU     = NUM_USERS;

    typedef struct packed {
        seq_st_e                   st;
        logic [NU-1:0][NUM_CH-1:0] cmask;
        logic [NU-1:0]             cavg;
        logic [NU-1:0]             pend;
        logic [NUM_CH-1:0]         mask;
        logic                      avg;
        logic [USER_W-1:0]         user;
        logic [CH_W-1:0]           ch;
        logic [ACQ_W-1:0]          cnt;
        logic [1:0]                samp;
        logic [RES_W-1:0]          acc;
        logic [NU-1:0]             eos;
    } seq_t;

    seq_t q, d;

    logic [NU-1:0]             req_vec;
    logic [NU-1:0][NUM_CH-1:0] in_mask;
    logic [NU-1:0]             in_avg;
    logic                      gnt_vld;
    logic [USER_W-1:0]         gnt_idx;
    logic                      pick_vld;
    logic [CH_W-1:0]           pick_idx;
    logic                      res_we;
    logic [RES_W-1:0]          res_val;
    logic [RES_W-1:0]          sum;

    assign req_vec = {usb_req, sw2_req, sw1_req, rt_req};
    assign in_mask = {NUM_CH'(1) << USB_CH, sw2_mask, sw1_mask, rt_mask};
    assign in_avg  = {usb_avg, sw2_avg, sw1_avg, rt_avg};
    assign sum     = q.acc + RES_W'(adc_data);

    adc_share_arb #(.N(NU), .IW(USER_W)) arb_i (
        .req     (q.pend),
        .gnt_vld (gnt_vld),
        .gnt_idx (gnt_idx)
    );

    adc_share_pick #(.CH_W(CH_W)) pick_i (
        .mask (q.mask),
        .vld  (pick_vld),
        .idx  (pick_idx)
    );

    always_comb begin
        d       = q;
        d.eos   = '0;
        res_we  = 1'b0;
        res_val = '0;
        for (int u = 0; u < NU; u++) begin
            if (req_vec[u]) begin
                d.pend[u]  = 1'b1;
                d.cmask[u] = in_mask[u];
                d.cavg[u]  = in_avg[u];
            end
        end
        unique case (q.st)
            ST_IDLE: begin
                if (gnt_vld) begin
                    d.user          = gnt_idx;
                    d.mask          = q.cmask[gnt_idx];
                    d.avg           = q.cavg[gnt_idx];
                    d.pend[gnt_idx] = req_vec[gnt_idx];
                    d.st            = ST_SEL;
                end
            end
            ST_SEL: begin
                if (pick_vld) begin
                    d.ch   = pick_idx;
                    d.samp = '0;
                    d.acc  = '0;
                    d.cnt  = acq_time;
                    d.st   = ST_ACQ;
                end else begin
                    d.eos[q.user] = 1'b1;
                    d.st          = ST_IDLE;
                end
            end
            ST_ACQ: begin
                if (q.cnt == '0) d.st = ST_START;
                else             d.cnt = q.cnt - 1'b1;
            end
            ST_START: d.st = ST_WAIT;
            ST_WAIT: begin
                if (adc_done) begin
                    if (q.avg && q.samp != 2'd3) begin
                        d.acc  = sum;
                        d.samp = q.samp + 1'b1;
                        d.cnt  = acq_time;
                        d.st   = ST_ACQ;
                    end else begin
                        res_we       = 1'b1;
                        res_val      = q.avg ? sum : {adc_data, {FRAC_W{1'b0}}};
                        d.mask[q.ch] = 1'b0;
                        d.st         = ST_SEL;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign adc_start = (q.st == ST_START);
    assign adc_ch    = q.ch;
    assign eos_irq   = q.eos;

    adc_share_res #(.USER_W(USER_W), .CH_W(CH_W), .RES_W(RES_W)) res_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (res_we),
        .wr_user (q.user),
        .wr_ch   (q.ch),
        .wr_val  (res_val),
        .rd_user (rd_user),
        .rd_ch   (rd_ch),
        .rd_val  (rd_val)
    );

    // R12
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    // R9
    eos_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eos_irq));

    // R7
    usb_ch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_start && q.user == USER_W'(3)) |-> (adc_ch == CH_W'(USB_CH)));

    // R2
    arb_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld |-> (q.pend[gnt_idx] &&
                     ((q.pend & ((NU'(1) << gnt_idx) - NU'(1))) == '0)));

    // R5
    plain_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we && !q.avg) |-> (res_val[FRAC_W-1:0] == '0));

    generate
        for (genvar u = 0; u < NU; u++) begin : g_pend
            // R3
            pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(q.pend[u]) |-> ($past(q.st) == ST_IDLE && $past(gnt_vld) &&
                                      $past(gnt_idx) == USER_W'(u)));
        end
    endgenerate
endmodule

// File: tb/adc_share_seq_tb_top.sv
module adc_share_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rt_req = 0, sw1_req = 0, sw2_req = 0, usb_req = 0;
    logic [15:0] rt_mask = 0, sw1_mask = 0, sw2_mask = 0;
    logic        rt_avg = 0, sw1_avg = 0, sw2_avg = 0, usb_avg = 0;
    logic [7:0]  acq_time = 0;
    logic        adc_start;
    logic [3:0]  adc_ch;
    logic        adc_done = 0;
    logic [9:0]  adc_data = 0;
    logic [3:0]  eos_irq;
    logic [1:0]  rd_user = 0;
    logic [3:0]  rd_ch = 0;
    logic [11:0] rd_val;

    int n_chk = 0, n_fail = 0;
    int conv_n = 0, eos_n = 0;
    int conv_ch [64];
    int eos_log [16];
    int samp_cnt [16];
    int seed = 0;
    bit full = 0;
    int cyc = 0, t_done = 0, last_gap = 0;
    bit have_done = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc++;

    adc_share_seq dut_i (
        .clk(clk), .rst_n(rst_n),
        .rt_req(rt_req), .rt_mask(rt_mask), .rt_avg(rt_avg),
        .sw1_req(sw1_req), .sw1_mask(sw1_mask), .sw1_avg(sw1_avg),
        .sw2_req(sw2_req), .sw2_mask(sw2_mask), .sw2_avg(sw2_avg),
        .usb_req(usb_req), .usb_avg(usb_avg), .acq_time(acq_time),
        .adc_start(adc_start), .adc_ch(adc_ch), .adc_done(adc_done),
        .adc_data(adc_data), .eos_irq(eos_irq),
        .rd_user(rd_user), .rd_ch(rd_ch), .rd_val(rd_val)
    );

    function automatic int fval(int ch, int k);
        return full ? 1023 : ((ch * 50 + k * 7 + seed) % 1024);
    endfunction

    // converter model: done two negedges after a start is seen
    initial begin
        forever begin
            @(negedge clk);
            adc_done = 1'b0;
            if (adc_start) begin
                automatic int ch = int'(adc_ch);
                if (have_done) last_gap = cyc - t_done;
                if (conv_n < 64) conv_ch[conv_n] = ch;
                conv_n++;
                repeat (2) @(negedge clk);
                adc_data  = 10'(fval(ch, samp_cnt[ch]));
                samp_cnt[ch]++;
                adc_done  = 1'b1;
                t_done    = cyc;
                have_done = 1'b1;
            end
        end
    end

    always @(negedge clk) begin
        for (int u = 0; u < 4; u++)
            if (eos_irq[u]) begin
                if (eos_n < 16) eos_log[eos_n] = u;
                eos_n++;
            end
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic clr();
        conv_n = 0; eos_n = 0; have_done = 0; full = 0;
        for (int i = 0; i < 16; i++) samp_cnt[i] = 0;
    endtask

    task automatic wait_eos(input int n);
        for (int i = 0; i < 3000 && eos_n < n; i++) @(posedge clk);
        repeat (20) @(posedge clk);
    endtask

    task automatic rd(input int u, input int ch, output int v);
        @(negedge clk);
        rd_user = 2'(u); rd_ch = 4'(ch);
        #1 v = int'(rd_val);
    endtask

    task automatic pulse(input int u);
        @(negedge clk);
        case (u)
            0: rt_req = 1; 1: sw1_req = 1; 2: sw2_req = 1; default: usb_req = 1;
        endcase
        @(negedge clk);
        rt_req = 0; sw1_req = 0; sw2_req = 0; usb_req = 0;
    endtask

    task automatic t_reset();
        int v;
        chk(adc_start == 0, "R1 start", adc_start, 0);
        chk(eos_irq == 0, "R1 eos", eos_irq, 0);
        rd(2, 7, v);
        chk(v == 0, "R1 result", v, 0);
    endtask

    task automatic t_plain();
        int v;
        clr(); seed = 100;
        sw1_mask = 16'h000A; sw1_avg = 0;
        pulse(1); wait_eos(1);
        chk(conv_n == 2, "R4 count", conv_n, 2);
        chk(conv_ch[0] == 1 && conv_ch[1] == 3, "R4 order", conv_ch[0], 1);
        rd(1, 1, v); chk(v == 4 * fval(1, 0), "R5 ch1", v, 4 * fval(1, 0));
        rd(1, 3, v); chk(v == 4 * fval(3, 0), "R5 ch3", v, 4 * fval(3, 0));
        chk(eos_n == 1 && eos_log[0] == 1, "R9 eos user", eos_log[0], 1);
    endtask

    task automatic t_avg();
        int v, e;
        clr(); seed = 333;
        sw2_mask = 16'h0020; sw2_avg = 1;
        pulse(2); wait_eos(1);
        chk(conv_n == 4, "R6 count", conv_n, 4);
        e = fval(5, 0) + fval(5, 1) + fval(5, 2) + fval(5, 3);
        rd(2, 5, v); chk(v == e, "R6 sum", v, e);
    endtask

    task automatic t_full();
        int v;
        clr(); full = 1;
        sw2_mask = 16'h0040; sw2_avg = 1;
        pulse(2); wait_eos(1);
        rd(2, 6, v); chk(v == 4092, "R6 fullscale", v, 4092);
    endtask

    task automatic t_usb();
        int v;
        clr(); seed = 7; usb_avg = 0;
        pulse(3); wait_eos(1);
        chk(conv_n == 1 && conv_ch[0] == 12, "R7 channel", conv_ch[0], 12);
        rd(3, 12, v); chk(v == 4 * fval(12, 0), "R7 result", v, 4 * fval(12, 0));
    endtask

    task automatic t_rt_edges();
        int v;
        clr(); seed = 900;
        rt_mask = 16'h8001; rt_avg = 0;
        pulse(0); wait_eos(1);
        chk(conv_n == 2 && conv_ch[0] == 0 && conv_ch[1] == 15, "R8 edges", conv_ch[1], 15);
        rd(0, 15, v); chk(v == 4 * fval(15, 0), "R8 ch15", v, 4 * fval(15, 0));
    endtask

    task automatic t_prio();
        clr(); seed = 11;
        rt_mask = 16'h0002; sw1_mask = 16'h0004; sw2_mask = 16'h0008;
        rt_avg = 0; sw1_avg = 0; sw2_avg = 0; usb_avg = 0;
        @(negedge clk);
        rt_req = 1; sw1_req = 1; sw2_req = 1; usb_req = 1;
        @(negedge clk);
        rt_req = 0; sw1_req = 0; sw2_req = 0; usb_req = 0;
        wait_eos(4);
        chk(eos_n == 4, "R3 all served", eos_n, 4);
        for (int i = 0; i < 4; i++)
            chk(eos_log[i] == i, "R2 order", eos_log[i], i);
    endtask

    task automatic t_rereq();
        clr(); seed = 50;
        sw1_mask = 16'h0004; sw1_avg = 1;
        pulse(1);
        repeat (3) @(negedge clk);
        pulse(1);
        repeat (2) @(negedge clk);
        pulse(1);
        wait_eos(2);
        repeat (200) @(posedge clk);
        chk(eos_n == 2, "R11 eos count", eos_n, 2);
        chk(conv_n == 8, "R11 conversions", conv_n, 8);
    endtask

    task automatic t_acq();
        int g0, g6;
        clr(); seed = 5; acq_time = 0;
        sw1_mask = 16'h0010; sw1_avg = 1;
        pulse(1); wait_eos(1); g0 = last_gap;
        clr(); acq_time = 6;
        pulse(1); wait_eos(1); g6 = last_gap;
        chk(g6 - g0 == 6, "R10 acq delay", g6 - g0, 6);
        chk(conv_n == 4, "R12 one start per done", conv_n, 4);
        acq_time = 0;
    endtask

    task automatic t_empty();
        clr();
        sw2_mask = 16'h0000; sw2_avg = 0;
        pulse(2); wait_eos(1);
        chk(eos_n == 1 && eos_log[0] == 2, "R9 empty eos", eos_n, 1);
        chk(conv_n == 0, "R9 empty conv", conv_n, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_plain();
        t_avg();
        t_full();
        t_usb();
        t_rt_edges();
        t_prio();
        t_rereq();
        t_acq();
        t_empty();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule